// File: doc/BRIEF.md
# In-order scoreboard issue controller

This block sits between an instruction decoder and four execution units and decides, cycle by cycle, whether the next decoded instruction may leave. Each instruction names the class of unit it needs, one destination register and two source registers. The block issues at most one instruction per cycle, strictly in program order. An instruction waits while its unit is occupied, while either source is still waiting for a result, or while its destination already has a result on the way. There is no renaming, so two writes to the same register are never in flight together.

The four units are integer/load, add, multiply and divide. Each is modelled as a fixed-latency countdown inside the block and holds one instruction at a time. A unit announces writeback of its destination register a fixed number of cycles after the issue cycle. In that cycle the unit and the register are released, and both can be used again from the following cycle. The decoder presents an instruction with `inValid` and holds it until it sees `inReady` high in the same cycle. That cycle is the issue cycle, and it is marked by `issueFire`.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset no register is reserved, no unit is busy and `wbValid` is all zeros, so any valid instruction is ready in the first cycle after reset.
- R2: `issueFire` is high exactly when `inValid` and `inReady` are both high, and `issueUnit` then equals `inUnit`. Unit codes are 0 integer/load, 1 add, 2 multiply, 3 divide. At most one instruction issues per cycle.
- R3: An instruction issued in cycle t on a unit of latency L, with defaults 1, 1, 3 and 4 for codes 0 to 3, raises `wbValid[unit]` in cycle t+L only. In that cycle `wbRegs[unit*4 +: 4]` carries its destination.
- R4: While a destination register has a write pending, a later instruction writing the same register is not ready.
- R5: While either source register of an instruction has a write pending, that instruction is not ready.
- R6: While its unit is busy an instruction is not ready. The earliest issue on the same unit is the cycle after the previous occupant's writeback.
- R7: A register or unit released by writeback in cycle t still blocks issue in cycle t and no longer blocks it in cycle t+1.
- R8: Several units may write back in the same cycle, and each is reported on its own `wbValid` bit with its own register field.
- R9: A stalled instruction blocks all younger instructions. With the six-instruction sequence DIV r6←r6,r4; LD r2←r3; MUL r0←r2,r4; DIV r8←r6,r2; SUB r10←r0,r6; ADD r6←r8,r2 presented back to back from cycle 0, the issue cycles are 0, 1, 3, 5, 7 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decoded instruction present |
| inUnit | input | 2 | Unit class code (0 int/load, 1 add, 2 mul, 3 div) |
| inDst | input | 4 | Destination register |
| inSrcA | input | 4 | First source register |
| inSrcB | input | 4 | Second source register |
| inReady | output | 1 | Instruction on the input may issue this cycle |
| issueFire | output | 1 | Issue pulse |
| issueUnit | output | 2 | Unit receiving the issued instruction |
| wbValid | output | 4 | Per-unit writeback this cycle, bit index = unit code |
| wbRegs | output | 16 | Per-unit writeback register, unit u at bits u*4 +: 4 |

## Verification
`inReady`, `issueFire` and `issueUnit` are combinational in the cycle the instruction is presented. Writeback shows L cycles after the issue cycle, and a released register stops blocking one cycle after that. The bench drives each cycle's inputs just after the falling edge and samples all outputs 1 ns later, before the next rising edge. A bench model of reservations and countdowns gives the expected values for that same cycle. Directed sequences also compare the recorded issue and writeback cycle numbers against hand-derived values.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = 2;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 issue;
    logic [NUM_UNITS-1:0] unitSel;
  } issue_strobe_t;
endpackage

// File: rtl/sb_unit_timer.sv
module sb_unit_timer #(
  parameter int LAT   = 1,
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REG_W-1:0] startDst,
  output logic             busy,
  output logic             done,
  output logic [REG_W-1:0] doneDst
);
  localparam int CNT_W = (LAT < 1) ? 1 : $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] dstQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      dstQ <= '0;
    end else if (start) begin
      cnt  <= CNT_W'(LAT);
      dstQ <= startDst;
    end else if (cnt != '0) begin
      cnt  <= cnt - CNT_W'(1);
    end
  end

  assign busy    = (cnt != '0);
  assign done    = (cnt == CNT_W'(1));
  assign doneDst = dstQ;

  // R6: a unit is only started when idle
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R3: the cycle after start the unit is occupied
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int LAT_INT  = 1,
  parameter int LAT_ADD  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  issue_strobe_t              strobe,
  input  logic [REG_W-1:0]           issueDst,
  output logic [NUM_UNITS-1:0]       busyVec,
  output logic [NUM_REGS-1:0]        resVec,
  output logic [NUM_UNITS-1:0]       wbValid,
  output logic [NUM_UNITS*REG_W-1:0] wbRegs
);
  logic [REG_W-1:0]    doneDst [NUM_UNITS];
  logic [NUM_REGS-1:0] clrMask;
  logic [NUM_REGS-1:0] setMask;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int L = (u == 0) ? LAT_INT :
                       (u == 1) ? LAT_ADD :
                       (u == 2) ? LAT_MUL : LAT_DIV;
    sb_unit_timer #(.LAT(L), .REG_W(REG_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (strobe.unitSel[u]),
      .startDst (issueDst),
      .busy     (busyVec[u]),
      .done     (wbValid[u]),
      .doneDst  (doneDst[u])
    );
    assign wbRegs[u*REG_W +: REG_W] = doneDst[u];

    // R7: a register written back is free in the following cycle
    p_wb_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wbValid[u] |=> !resVec[$past(doneDst[u])]);
    // R3: a writing unit still holds its register reserved
    p_wb_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wbValid[u] |-> resVec[doneDst[u]]);
  end

  always_comb begin
    clrMask = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (wbValid[u]) clrMask[doneDst[u]] = 1'b1;
    setMask = '0;
    if (strobe.issue) setMask[issueDst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resVec <= '0;
    else        resVec <= (resVec & ~clrMask) | setMask;
  end

  // R4: no second write to a reserved register
  p_issue_free_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |-> !resVec[issueDst]);
  // R6: issue never targets a busy unit
  p_issue_unit_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |-> ((strobe.unitSel & busyVec) == '0));
  // R2: one unit at most, exactly one on issue
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.unitSel) && (strobe.issue == (strobe.unitSel != '0)));
endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                 inValid,
  input  logic [UNIT_W-1:0]    inUnit,
  input  logic [REG_W-1:0]     inDst,
  input  logic [REG_W-1:0]     inSrcA,
  input  logic [REG_W-1:0]     inSrcB,
  input  logic [NUM_UNITS-1:0] busyVec,
  input  logic [NUM_REGS-1:0]  resVec,
  output logic                 inReady,
  output issue_strobe_t        strobe
);
  logic unitBusy;
  logic wawHaz;
  logic rawHaz;

  always_comb begin
    unitBusy       = busyVec[inUnit];
    wawHaz         = resVec[inDst];
    rawHaz         = resVec[inSrcA] | resVec[inSrcB];
    inReady        = !(unitBusy | wawHaz | rawHaz);
    strobe.issue   = inValid & inReady;
    strobe.unitSel = strobe.issue ? (NUM_UNITS'(1) << inUnit) : '0;
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int LAT_INT  = 1,
  parameter int LAT_ADD  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inValid,
  input  logic [UNIT_W-1:0]          inUnit,
  input  logic [REG_W-1:0]           inDst,
  input  logic [REG_W-1:0]           inSrcA,
  input  logic [REG_W-1:0]           inSrcB,
  output logic                       inReady,
  output logic                       issueFire,
  output logic [UNIT_W-1:0]          issueUnit,
  output logic [NUM_UNITS-1:0]       wbValid,
  output logic [NUM_UNITS*REG_W-1:0] wbRegs
);
  issue_strobe_t        strobe;
  logic [NUM_UNITS-1:0] busyVec;
  logic [NUM_REGS-1:0]  resVec;

  sb_control #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .inValid (inValid),
    .inUnit  (inUnit),
    .inDst   (inDst),
    .inSrcA  (inSrcA),
    .inSrcB  (inSrcB),
    .busyVec (busyVec),
    .resVec  (resVec),
    .inReady (inReady),
    .strobe  (strobe)
  );

  sb_datapath #(
    .NUM_REGS(NUM_REGS), .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD),
    .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .issueDst (inDst),
    .busyVec  (busyVec),
    .resVec   (resVec),
    .wbValid  (wbValid),
    .wbRegs   (wbRegs)
  );

  assign issueFire = strobe.issue;
  assign issueUnit = inUnit;

  // R5: sources of an issued instruction have no pending write
  p_issue_no_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issueFire |-> (!resVec[inSrcA] && !resVec[inSrcB]));
  // R1: nothing pending in the first cycle out of reset
  p_reset_clean_r1: assert property (@(posedge clk)
    !rst_n |=> (resVec == '0 && busyVec == '0));
endmodule

// File: tb/sb_issue_ctrl_test.sv
`timescale 1ns/100ps
module sb_issue_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inUnit = '0;
  logic [3:0]  inDst = '0, inSrcA = '0, inSrcB = '0;
  logic        inReady, issueFire;
  logic [1:0]  issueUnit;
  logic [3:0]  wbValid;
  logic [15:0] wbRegs;

  int total = 0;
  int bad = 0;
  int cycleNo = 0;
  int lat [4] = '{1, 1, 3, 4};
  int mCnt [4];
  int mDst [4];
  bit [15:0] mRes;
  logic [3:0] wbAt [64];

  sb_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inUnit(inUnit),
    .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB), .inReady(inReady),
    .issueFire(issueFire), .issueUnit(issueUnit), .wbValid(wbValid),
    .wbRegs(wbRegs)
  );

  always #2.5 clk = ~clk;

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycleNo, act, exp);
    end
  endtask

  function automatic bit expReady(input int u, input int d, input int a, input int b);
    return (mCnt[u] == 0) && !mRes[d] && !mRes[a] && !mRes[b];
  endfunction

  // sample all outputs against the model for the current cycle
  task automatic checkCycle(input bit v, input int u, input int d, input int a,
                            input int b, output bit fired);
    bit r;
    logic [3:0] ew;
    r = expReady(u, d, a, b);
    fired = v && r;
    chk(inReady == r, "R2 inReady", int'(inReady), int'(r));
    chk(issueFire == fired, "R2 issueFire", int'(issueFire), int'(fired));
    if (fired) chk(issueUnit == 2'(u), "R2 issueUnit", int'(issueUnit), u);
    for (int k = 0; k < 4; k++) ew[k] = (mCnt[k] == 1);
    chk(wbValid == ew, "R3 wbValid", int'(wbValid), int'(ew));
    for (int k = 0; k < 4; k++)
      if (ew[k]) chk(wbRegs[k*4 +: 4] == 4'(mDst[k]), "R3 wbRegs",
                     int'(wbRegs[k*4 +: 4]), mDst[k]);
    if (cycleNo >= 0 && cycleNo < 64) wbAt[cycleNo] = wbValid;
  endtask

  task automatic advance(input bit fired, input int u, input int d);
    @(posedge clk);
    cycleNo++;
    for (int k = 0; k < 4; k++) begin
      if (mCnt[k] == 1) mRes[mDst[k]] = 1'b0;
      if (mCnt[k] > 0) mCnt[k]--;
    end
    if (fired) begin
      mCnt[u] = lat[u];
      mDst[u] = d;
      mRes[d] = 1'b1;
    end
  endtask

  task automatic issueOne(input int u, input int d, input int a, input int b,
                          output int at);
    bit f;
    at = -1;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      inValid = 1'b1; inUnit = 2'(u); inDst = 4'(d); inSrcA = 4'(a); inSrcB = 4'(b);
      #1;
      checkCycle(1'b1, u, d, a, b, f);
      if (f) at = cycleNo;
      advance(f, u, d);
      if (f) break;
    end
  endtask

  task automatic idle(input int n);
    bit f;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      #1;
      checkCycle(1'b0, int'(inUnit), int'(inDst), int'(inSrcA), int'(inSrcB), f);
      advance(1'b0, 0, 0);
    end
  endtask

  task automatic startSeq();
    idle(6);
    cycleNo = 0;
    for (int i = 0; i < 64; i++) wbAt[i] = '0;
  endtask

  int t0, t1, t2, t3, t4, t5;

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin mCnt[k] = 0; mDst[k] = 0; end
    mRes = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, any valid instruction ready
    inValid = 1'b1; inUnit = 2'd3; inDst = 4'd15; inSrcA = 4'd15; inSrcB = 4'd0;
    #1;
    chk(wbValid == 4'b0, "R1 wbValid after reset", int'(wbValid), 0);
    chk(inReady == 1'b1, "R1 inReady after reset", int'(inReady), 1);
    inValid = 1'b0;
    #0.5;
    chk(issueFire == 1'b0, "R1 no issue without valid", int'(issueFire), 0);

    // R9 / R4 / R5 / R6: six-instruction sequence
    startSeq();
    issueOne(3, 6, 6, 4, t0);
    issueOne(0, 2, 3, 3, t1);
    issueOne(2, 0, 2, 4, t2);
    issueOne(3, 8, 6, 2, t3);
    issueOne(1, 10, 0, 6, t4);
    issueOne(1, 6, 8, 2, t5);
    idle(3);
    chk(t0 == 0, "R9 seq i1 issue", t0, 0);
    chk(t1 == 1, "R9 seq i2 issue", t1, 1);
    chk(t2 == 3, "R5 seq i3 waits for load", t2, 3);
    chk(t3 == 5, "R6 seq i4 waits for divider", t3, 5);
    chk(t4 == 7, "R5 seq i5 waits for mul", t4, 7);
    chk(t5 == 10, "R9 seq i6 issue", t5, 10);
    chk(wbAt[4][3] == 1'b1, "R3 div wb at issue+4", int'(wbAt[4][3]), 1);
    chk(wbAt[3][3] == 1'b0, "R3 div no wb at issue+3", int'(wbAt[3][3]), 0);
    chk(wbAt[2][0] == 1'b1, "R3 load wb at issue+1", int'(wbAt[2][0]), 1);
    chk(wbAt[11][1] == 1'b1, "R3 add wb at issue+1", int'(wbAt[11][1]), 1);

    // R7: register freed by writeback in t usable in t+1
    startSeq();
    issueOne(0, 5, 1, 1, t0);
    issueOne(1, 9, 5, 2, t1);
    chk(t1 == 2, "R7 reader issues cycle after wb", t1, 2);

    // R4: pending write blocks second writer
    startSeq();
    issueOne(2, 7, 1, 1, t0);
    issueOne(0, 7, 2, 2, t1);
    chk(t1 == 4, "R4 second writer after mul wb", t1, 4);

    // R8: two units write back together
    startSeq();
    issueOne(2, 1, 4, 4, t0);
    issueOne(1, 2, 4, 4, t1);
    issueOne(0, 3, 4, 4, t2);
    idle(3);
    chk(wbAt[3] == 4'b0101, "R8 mul and int wb same cycle", int'(wbAt[3]), 5);

    // R6: back-to-back on the divider
    startSeq();
    issueOne(3, 11, 0, 0, t0);
    issueOne(3, 12, 0, 0, t1);
    chk(t1 == 5, "R6 second div after first wb", t1, 5);

    // random phase, every cycle checked against the model (R2, R3)
    idle(6);
    for (int i = 0; i < 600; i++) begin
      int u, d, a, b, at;
      u = int'($urandom_range(0, 3));
      d = int'($urandom_range(0, 7));
      a = int'($urandom_range(0, 7));
      b = int'($urandom_range(0, 15));
      issueOne(u, d, a, b, at);
      chk(at >= 0, "R2 random instruction issued", at, 0);
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule